// File: doc/BRIEF.md
# Expansion Bus Cycle Sequencer

This block runs processor-initiated transfers on an 8-bit demultiplexed expansion bus with a 20-bit address. A processor-side port presents a request: a kind, an address and a valid flag. The sequencer then drives the address latch enable pulse and latches the address. It drives one of four active-low command strobes: memory read, memory write, I/O read or I/O write. When the cycle is over it pulses a completion flag. A memory cycle lasts four clocks and an I/O cycle lasts five. A slow device can stretch the final clock of either cycle by holding the channel ready input low. The stretch is bounded: after ten extra clocks the cycle is forced to end and a time-out flag is raised.

A free-running requester asks for a dynamic-memory refresh slot every 72 clocks. The sequencer serves that request at the next point where it is idle. For four clocks it then owns the bus. During that time it drives the address-enable output high and the refresh acknowledge low, and it performs a memory read with no processor strobe. A refresh never splits a processor cycle. The refresh schedule keeps its own pace, no matter how late a given slot was served.

Top module: `xbus_cycle_seq`

## Requirements
- R1: A memory cycle (req_kind 00 = memory read, 01 = memory write) lasts 4 clocks when rdy stays high. In clock 1, ale is high and no strobe is active. In clocks 2 to 4, the matching strobe (memr_n or memw_n) is low. In the clock after the cycle, req_done is high for one clock and all strobes are high.
- R2: An I/O cycle (req_kind 10 = I/O read, 11 = I/O write) lasts 5 clocks when rdy stays high. ior_n or iow_n is low in clocks 2 to 5.
- R3: rdy is sampled at the end of a cycle's final clock. Each sample taken low repeats that clock, so the cycle is stretched in whole clocks. The cycle ends at the first high sample.
- R4: If rdy is still low after 10 stretched clocks, the cycle ends anyway. rdy_timeout is then high for one clock, together with req_done. A cycle that ends normally leaves rdy_timeout low.
- R5: The refresh requester fires at clock edge 72 after reset release and on every 72nd edge after that. A served refresh occupies 4 clocks. In all four, aen is high and dack0_n is low. memr_n is low in clocks 2 to 4.
- R6: The address on req_addr is captured at the clock edge where ale falls. bus_addr then holds that value for the rest of the cycle, and later changes on req_addr have no effect on it.
- R7: At most one of memr_n, memw_n, ior_n and iow_n is low at any time, and none is low while ale is high.
- R8: While aen is high, memw_n, ior_n and iow_n stay high and ale stays low.
- R9: A pending refresh waits for the sequencer to be idle and never splits a processor cycle. A pending refresh wins over a processor request in the idle state. The slot after a late refresh is still timed from the original request point.
- R10: rst_n is a synchronous, active-low reset. After a clock edge with rst_n low, the sequencer is idle: all strobes and dack0_n are high, ale, aen, req_done and rdy_timeout are low, and bus_addr is zero.
- R11: A request is accepted only from idle, and never in the clock in which req_done is high. With req_valid held high, the next ale therefore appears two clocks after req_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_kind | input | 2 | Transfer kind: 00 memory read, 01 memory write, 10 I/O read, 11 I/O write |
| req_addr | input | 20 | Request address |
| rdy | input | 1 | Channel ready; low stretches the final clock |
| req_done | output | 1 | One-clock completion pulse after a processor cycle |
| rdy_timeout | output | 1 | One-clock flag: cycle ended by the ready limit |
| ale | output | 1 | Address latch enable, high in a processor cycle's first clock |
| bus_addr | output | 20 | Latched bus address |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| aen | output | 1 | Address enable, high while the refresh slot owns the bus |
| dack0_n | output | 1 | Refresh acknowledge, active low |

## Verification
The assertions take two things for granted. First, the processor holds req_kind stable from the clock its request is accepted until req_done. Second, it holds req_addr stable through the first clock of the cycle, so the address captured when ale falls is meaningful. The stimulus drives every input at the falling clock edge. It changes req_addr only from the second clock of a cycle onward, which is after capture, so that the hold check means something. It drops or replaces req_valid only after it has seen req_done. rdy is raised at a falling edge that the bench computes from the cycle's base length and the intended stretch, so that the stretched cycle length is exact.

// File: rtl/xbus_pkg.sv
// Shared types for the expansion bus cycle sequencer.
// Assumes: transfer kind bit 1 selects I/O space, bit 0 selects write.
package xbus_pkg;

    typedef enum logic [1:0] {
        KIND_MEM_RD = 2'b00,
        KIND_MEM_WR = 2'b01,
        KIND_IO_RD  = 2'b10,
        KIND_IO_WR  = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_CPU  = 2'b01,
        SEQ_RFSH = 2'b10
    } seq_state_e;

endpackage

// File: rtl/xbus_rfsh_timer.sv
// Periodic refresh requester.
// It counts clocks free-running from reset and raises a sticky pending flag
// every PERIOD edges. The flag clears when the sequencer takes the slot.
// Assumes: take is only asserted while pend is high.
module xbus_rfsh_timer #(
    parameter int PERIOD = 72
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic pend
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == CW'(PERIOD - 1));

    // Free-running period counter; the schedule never shifts with service.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (tick) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    // Pending flag: set on each period tick, cleared when the slot is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else if (tick) pend <= 1'b1;
        else if (take) pend <= 1'b0;
    end

    // R9: a pending request survives until it is served
    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !take) |=> pend);

    // R9: the sequencer only takes a slot that is pending
    p_take_only_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend);

endmodule

// File: rtl/xbus_wait_ctrl.sv
// Ready stretch and time-out control for the final clock of a processor cycle.
// While at_last is high, each low sample of rdy repeats the clock, up to LIMIT
// times. After that the cycle is finished anyway and tmo is raised.
// Assumes: at_last stays high until finish.
module xbus_wait_ctrl #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic at_last,
    input  logic rdy,
    output logic finish,
    output logic tmo
);
    localparam int WW = $clog2(LIMIT + 1);

    logic [WW-1:0] wcnt;
    logic          at_limit;

    assign at_limit = (wcnt == WW'(LIMIT));
    assign finish   = at_last && (rdy || at_limit);
    assign tmo      = at_last && !rdy && at_limit;

    // Count stretched clocks; the count starts over for every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) wcnt <= '0;
        else if (!at_last || finish) wcnt <= '0;
        else wcnt <= wcnt + 1'b1;
    end

    // R4: the stretch count never passes the limit
    p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= WW'(LIMIT));

    // R3: a stretched clock is recorded in the count
    p_stretch_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && !finish) |=> (wcnt != '0));

endmodule

// File: rtl/xbus_strobe_dec.sv
// Decodes sequencer state, phase and transfer kind into the bus control pins.
// Phase 1 of a processor cycle is the address-latch clock; later phases drive
// one command strobe. A refresh slot raises aen and reads memory from phase 2.
// Assumes: phase counts from 1.
module xbus_strobe_dec #(
    parameter int PH_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  xbus_pkg::seq_state_e   st,
    input  logic [PH_W-1:0]        ph,
    input  xbus_pkg::xfer_kind_e   kind,
    output logic                   ale,
    output logic                   memr_n,
    output logic                   memw_n,
    output logic                   ior_n,
    output logic                   iow_n,
    output logic                   aen,
    output logic                   dack0_n
);
    import xbus_pkg::*;

    logic cpu_cmd;
    logic rf_cmd;

    // Combinational pin decode from the registered sequencer state.
    always_comb begin
        cpu_cmd = (st == SEQ_CPU)  && (ph >= PH_W'(2));
        rf_cmd  = (st == SEQ_RFSH) && (ph >= PH_W'(2));
        ale     = (st == SEQ_CPU)  && (ph == PH_W'(1));
        aen     = (st == SEQ_RFSH);
        dack0_n = !(st == SEQ_RFSH);
        memr_n  = !((cpu_cmd && kind == KIND_MEM_RD) || rf_cmd);
        memw_n  = !(cpu_cmd && kind == KIND_MEM_WR);
        ior_n   = !(cpu_cmd && kind == KIND_IO_RD);
        iow_n   = !(cpu_cmd && kind == KIND_IO_WR);
    end

    // R7: never more than one command strobe at once
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~memr_n, ~memw_n, ~ior_n, ~iow_n}) <= 1);

    // R7: no command during the address-latch clock
    p_no_cmd_in_ale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (memr_n && memw_n && ior_n && iow_n));

    // R8: while aen owns the bus, the processor strobes and ale are blocked
    p_aen_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> (memw_n && ior_n && iow_n && !ale));

endmodule

// File: rtl/xbus_cycle_seq.sv
// Expansion bus cycle sequencer, top level.
// It sequences processor memory and I/O cycles (base lengths MEM_CLKS and
// IO_CLKS), stretches the final clock on a low ready, ends runaway stretches
// after WAIT_LIMIT clocks, and slots in a RFSH_CLKS-long refresh every
// RFSH_PERIOD clocks at the next idle point.
// Assumes: req_kind is stable while a cycle runs; req_addr is stable during
// the first clock of a cycle.
module xbus_cycle_seq #(
    parameter int ADDR_W      = 20,
    parameter int MEM_CLKS    = 4,
    parameter int IO_CLKS     = 5,
    parameter int WAIT_LIMIT  = 10,
    parameter int RFSH_PERIOD = 72,
    parameter int RFSH_CLKS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              rdy,
    output logic              req_done,
    output logic              rdy_timeout,
    output logic              ale,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              memr_n,
    output logic              memw_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              aen,
    output logic              dack0_n
);
    import xbus_pkg::*;

    localparam int MAX_CPU  = (IO_CLKS > MEM_CLKS) ? IO_CLKS : MEM_CLKS;
    localparam int MAX_CLKS = (MAX_CPU > RFSH_CLKS) ? MAX_CPU : RFSH_CLKS;
    localparam int PH_W     = $clog2(MAX_CLKS + 1);

    seq_state_e        st;
    logic [PH_W-1:0]   ph;
    xfer_kind_e        kind;
    logic [PH_W-1:0]   cyc_len;
    logic              cpu_last;
    logic              cpu_finish;
    logic              cpu_tmo;
    logic              rf_pend;
    logic              rf_take;
    logic              done_q;
    logic              tmo_q;

    assign cyc_len  = kind[1] ? PH_W'(IO_CLKS) : PH_W'(MEM_CLKS);
    assign cpu_last = (st == SEQ_CPU) && (ph == cyc_len);
    assign rf_take  = (st == SEQ_IDLE) && rf_pend;

    xbus_rfsh_timer #(.PERIOD(RFSH_PERIOD)) u_rfsh (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (rf_take),
        .pend  (rf_pend)
    );

    xbus_wait_ctrl #(.LIMIT(WAIT_LIMIT)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .at_last (cpu_last),
        .rdy     (rdy),
        .finish  (cpu_finish),
        .tmo     (cpu_tmo)
    );

    xbus_strobe_dec #(.PH_W(PH_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .ph      (ph),
        .kind    (kind),
        .ale     (ale),
        .memr_n  (memr_n),
        .memw_n  (memw_n),
        .ior_n   (ior_n),
        .iow_n   (iow_n),
        .aen     (aen),
        .dack0_n (dack0_n)
    );

    // Cycle sequencer: idle arbitration, phase stepping, address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SEQ_IDLE;
            ph       <= PH_W'(1);
            kind     <= KIND_MEM_RD;
            bus_addr <= '0;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    ph <= PH_W'(1);
                    if (rf_pend) begin
                        st <= SEQ_RFSH;
                    end else if (req_valid && !done_q) begin
                        st   <= SEQ_CPU;
                        kind <= xfer_kind_e'(req_kind);
                    end
                end
                SEQ_CPU: begin
                    if (ph == PH_W'(1)) bus_addr <= req_addr;
                    if (!cpu_last) begin
                        ph <= ph + 1'b1;
                    end else if (cpu_finish) begin
                        st     <= SEQ_IDLE;
                        ph     <= PH_W'(1);
                        done_q <= 1'b1;
                        tmo_q  <= cpu_tmo;
                    end
                end
                SEQ_RFSH: begin
                    if (ph == PH_W'(RFSH_CLKS)) begin
                        st <= SEQ_IDLE;
                        ph <= PH_W'(1);
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    assign req_done    = done_q;
    assign rdy_timeout = tmo_q;

    // R6: the latched address holds through the command phase
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_CPU && ph > PH_W'(2)) |-> $stable(bus_addr));

    // R1: completion is a single-clock pulse
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R3: an unfinished final clock is repeated
    p_stretch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_last && !cpu_finish) |=> (st == SEQ_CPU && ph == $past(ph)));

    // R9: a processor cycle is never split by refresh
    p_no_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_CPU && !cpu_finish) |=> (st == SEQ_CPU));

    // R5: the refresh slot ends after its last clock
    p_rfsh_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_RFSH && ph == PH_W'(RFSH_CLKS)) |=> (st == SEQ_IDLE));

    // R4: a time-out flag only comes with completion
    p_tmo_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_timeout |-> req_done);

    // R10: a reset edge leaves every pin idle
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (memr_n && memw_n && ior_n && iow_n && dack0_n &&
                    !aen && !ale && !req_done && !rdy_timeout));

endmodule

// File: tb/xbus_cycle_seq_test.sv
// Self-checking bench for the expansion bus cycle sequencer.
module xbus_cycle_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [19:0] req_addr;
    logic        rdy;
    logic        req_done, rdy_timeout, ale, aen, dack0_n;
    logic        memr_n, memw_n, ior_n, iow_n;
    logic [19:0] bus_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xbus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .rdy(rdy), .req_done(req_done),
        .rdy_timeout(rdy_timeout), .ale(ale), .bus_addr(bus_addr),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
        .aen(aen), .dack0_n(dack0_n)
    );

    // Vector: {kind[2], addr[20], stretch[5], exp_len[5], exp_tmo[1]}
    localparam int NV = 6;
    localparam logic [32:0] VEC [NV] = '{
        {2'd0, 20'h12345, 5'd0,  5'd4,  1'b0},
        {2'd1, 20'hFFFFF, 5'd0,  5'd4,  1'b0},
        {2'd2, 20'h003F8, 5'd0,  5'd5,  1'b0},
        {2'd3, 20'h00060, 5'd2,  5'd7,  1'b0},
        {2'd0, 20'h80000, 5'd10, 5'd14, 1'b0},
        {2'd3, 20'h00001, 5'd12, 5'd15, 1'b1}
    };

    function automatic logic [3:0] strb();
        return {memr_n, memw_n, ior_n, iow_n};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; rdy = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One processor cycle from the table, measured from the ale clock.
    task automatic run_vec(input logic [32:0] v);
        logic [1:0]  kind;
        logic [19:0] addr;
        int w, exp_len, base, k, len;
        bit exp_tmo, pat_ok, addr_ok;
        logic [3:0] exp_s;
        kind = v[32:31]; addr = v[30:11]; w = int'(v[10:6]);
        exp_len = int'(v[5:1]); exp_tmo = v[0];
        base = kind[1] ? 5 : 4;
        exp_s = 4'b1111; exp_s[3 - int'(kind)] = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; rdy = (w == 0);
        k = 0;
        while (!ale && k < 200) begin @(negedge clk); k++; end
        chk("R1", "ale seen", int'(ale), 1);
        pat_ok = (strb() == 4'hF) && !aen;
        addr_ok = 1'b1; len = 0;
        for (int c = 2; c < 60; c++) begin
            @(negedge clk);
            if (req_done) begin
                len = c - 1;
                if (strb() != 4'hF) pat_ok = 1'b0;
                break;
            end
            if (strb() != exp_s || ale || aen) pat_ok = 1'b0;
            if (bus_addr != addr) addr_ok = 1'b0;
            if (c == 2) req_addr = ~addr;
            if (c == base + w) rdy = 1'b1;
        end
        if (w > 0) chk("R3", "stretched length", len, exp_len);
        else if (kind[1]) chk("R2", "I/O cycle length", len, exp_len);
        else chk("R1", "memory cycle length", len, exp_len);
        chk("R4", "timeout flag", int'(rdy_timeout), int'(exp_tmo));
        chk("R7", "strobe pattern", int'(pat_ok), 1);
        chk("R6", "address hold", int'(addr_ok), 1);
        req_valid = 1'b0; rdy = 1'b1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int rise1, rise2;
        bit prev_aen, rf_ok, quiet_ok;
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0; rdy = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "strobes idle", int'(strb()), 15);
        chk("R10", "aen/ale/dack0_n", int'({aen, ale, dack0_n}), 1);
        chk("R10", "done/timeout", int'({req_done, rdy_timeout}), 0);
        chk("R10", "bus_addr", int'(bus_addr), 0);

        // Back-to-back requests (R11) and the refresh schedule (R5)
        rst_n = 1'b1; req_valid = 1'b1; req_kind = 2'd0; req_addr = 20'h00ABC;
        rise1 = 0; rise2 = 0; prev_aen = 1'b0; rf_ok = 1'b1;
        for (int n = 1; n <= 150; n++) begin
            @(negedge clk);
            if (aen && !prev_aen) begin
                if (rise1 == 0) rise1 = n; else if (rise2 == 0) rise2 = n;
            end
            prev_aen = aen;
            if (n == 5) chk("R1", "done after 4 clocks", int'(req_done), 1);
            if (n == 6) chk("R11", "no ale in done-gap clock", int'(ale), 0);
            if (n == 7) begin
                chk("R11", "ale two clocks after done", int'(ale), 1);
                req_valid = 1'b0;
            end
            if (n == 73 && !(aen && !dack0_n && strb() == 4'hF && !ale)) rf_ok = 1'b0;
            if (n >= 74 && n <= 76 && !(aen && !dack0_n && strb() == 4'b0111 && !ale)) rf_ok = 1'b0;
            if (n == 77 && (aen || !dack0_n)) rf_ok = 1'b0;
        end
        chk("R5", "first refresh clock", rise1, 73);
        chk("R5", "refresh slot pattern", int'(rf_ok), 1);
        chk("R5", "second refresh clock", rise2, 145);

        // R9: refresh pends during a long cycle, then keeps its original pace
        do_reset();
        rise1 = 0; rise2 = 0; prev_aen = 1'b0; quiet_ok = 1'b1;
        for (int n = 1; n <= 150; n++) begin
            @(negedge clk);
            if (aen && !prev_aen) begin
                if (rise1 == 0) rise1 = n; else if (rise2 == 0) rise2 = n;
            end
            prev_aen = aen;
            if (n == 66) begin
                req_valid = 1'b1; req_kind = 2'd3; req_addr = 20'h00378; rdy = 1'b0;
            end
            if (n == 67) chk("R9", "cycle starts before tick", int'(ale), 1);
            if (n >= 67 && n <= 82 && aen) quiet_ok = 1'b0;
            if (n == 81) rdy = 1'b1;
            if (n == 82) begin
                chk("R9", "long cycle completes", int'(req_done), 1);
                req_valid = 1'b0;
            end
        end
        chk("R9", "no refresh inside cycle", int'(quiet_ok), 1);
        chk("R9", "deferred refresh clock", rise1, 83);
        chk("R9", "next refresh on original pace", rise2, 145);

        // Table of cycles: lengths, stretches, time-out, strobes, address
        do_reset();
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R10: reset in the middle of a command phase
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 20'h0F0F0;
        while (!ale) @(negedge clk);
        @(negedge clk);
        chk("R1", "write strobe active", int'(memw_n), 0);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk("R10", "mid-cycle reset strobes", int'(strb()), 15);
        chk("R10", "mid-cycle reset ale/aen/done", int'({ale, aen, req_done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "stays idle after reset", int'({ale, strb()}), 15);

        finish_run();
    end

endmodule